// File: doc/BRIEF.md
# Addressed Serial Configuration Register Loader

This block takes configuration for a multi-channel motor-drive controller over a three-wire serial link: a serial clock, a data line and a load strobe. A host shifts a 12-bit frame, most significant bit first. The upper nibble of the frame picks one of sixteen register slots and the lower byte is the value. The frame is written into the selected 8-bit register when the load strobe rises. Fourteen slots hold registers. The two highest slots are reserved, and a write to them is dropped.

The serial pins are not used as clocks. They pass through a synchronizer into the system clock domain, and their rising edges are found there. The system clock must run at more than four times the serial clock rate. The stored registers are decoded into parallel fields for the rest of the chip:
- two stepper channel pairs, each using four addresses
- one extra driver channel with its own divider and DAC code, using three addresses
- three plain bridge channels, one address each

Holding standby low, or raising undervoltage, clears every register and the frame shifter.

Top module: `cfg_serial_loader`

## Requirements
- R1: A frame is shifted on rising edges of `sck_i`, first bit first. Within the last 12 bits shifted, bits 11..8 are the address and bits 7..0 are the data.
- R2: Registers change only on a rising edge of `ld_i`, or on a clear. Shifting bits without a load-strobe rise leaves every output unchanged.
- R3: When more than 12 bits are shifted before the load strobe, only the last 12 are used.
- R4: A write to address 14 or 15 changes no output.
- R5: While `stby_ni` is low, every register and every output is zero, and frames loaded during that time are lost.
- R6: A high `uv_i` clears every register to zero.
- R7: Pair p uses addresses 4p to 4p+3, with the same layout for each pair:
  - base+0: bit7 mode, bit6 stepper select, bit5 current-control enable of channel a, bits4..0 divide ratio.
  - base+1: bit7 coarse resolution, bit6 counter reset, bits5..4 fast-decay count, bit3 90-degree monitor, bit2 current-control enable of channel b, bits1..0 current-limit code.
  - base+2: bits7..6 off period, bit5 reverse, bit4 channel-a input 1, bit3 channel-a input 2.
  - base+3: bit7 channel-b input 1, bit6 channel-b input 2.
  - `pair_ccen_o[p]` is {b, a}. `pair_bridge_o[p]` is {b in1, b in2, a in1, a in2}.
- R8: The extra channel uses three addresses:
  - address 8: bit7 mode, bit6 current-control enable, bits4..0 divide ratio.
  - address 9: bits7..6 off period, bit5 input 1, bit4 input 2, with `e_bridge_o` = {in1, in2}.
  - address 10: bits5..0 DAC code.
- R9: Address 11+k configures plain channel k: bit7 mode, bit6 input 1, bit5 input 2, with `aux_bridge_o[k]` = {in1, in2}.
- R10: A write changes only the addressed register. Fields decoded from other addresses keep their values.
- R11: After reset, every output is zero.
- R12: The new field values appear on the outputs on the third rising `clk_i` edge after `ld_i` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stby_ni | input | 1 | Standby, active low; clears all registers |
| uv_i | input | 1 | Undervoltage flag; clears all registers |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| ld_i | input | 1 | Load strobe; commits on rise |
| pair_mode_o | output | 2 | Drive-table select per pair |
| pair_step_o | output | 2 | Stepper select per pair |
| pair_ccen_o | output | 2x2 | Current-control enable {b,a} per pair |
| pair_div_o | output | 2x5 | Internal clock divide ratio per pair |
| pair_coarse_o | output | 2 | Coarse step resolution per pair |
| pair_cnt_rst_o | output | 2 | Step counter reset per pair |
| pair_fast_o | output | 2x2 | Fast-decay cycle count per pair |
| pair_mon90_o | output | 2 | Monitor every 90 degrees per pair |
| pair_ilim_o | output | 2x2 | Current-limit code per pair |
| pair_off_o | output | 2x2 | Off-period code per pair |
| pair_rev_o | output | 2 | Reverse direction per pair |
| pair_bridge_o | output | 2x4 | Bridge inputs {b1,b2,a1,a2} per pair |
| e_mode_o | output | 1 | Extra channel drive-table select |
| e_ccen_o | output | 1 | Extra channel current-control enable |
| e_div_o | output | 5 | Extra channel divide ratio |
| e_off_o | output | 2 | Extra channel off-period code |
| e_bridge_o | output | 2 | Extra channel bridge inputs {in1,in2} |
| e_dac_o | output | 6 | Extra channel DAC code |
| aux_mode_o | output | 3 | Drive-table select per plain channel |
| aux_bridge_o | output | 3x2 | Bridge inputs {in1,in2} per plain channel |

## Verification
Each kind of internal fault shows at the decoded outputs in its own way:
- A shifter that is off by one, or shifts in the wrong order, puts data into a neighbouring field or a neighbouring address. The fault appears at the first load-strobe rise.
- A broken address decode changes a field that should have kept its value. The bench catches this by comparing a snapshot of all the outputs taken before the write.
- A fault in edge detection or synchronizer depth moves the change of the outputs away from the third clock edge after the strobe rises. The cycle-exact check catches this.
- A clear path that fails leaves nonzero fields on the outputs during standby, and these are visible at once.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int FRAME_W  = 12;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 14;
  localparam int NPAIR    = 2;
  localparam int REGS_PER_PAIR = 4;
  localparam int E_BASE   = NPAIR * REGS_PER_PAIR;
  localparam int NAUX     = 3;
  localparam int AUX_BASE = E_BASE + 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/sync_vec.sv
module sync_vec #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import cfg_loader_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   sck_i,
  input  logic   sdi_i,
  input  logic   ld_i,
  output frame_t frame_o,
  output logic   commit_o
);
  logic               sck_prev_q, ld_prev_q;
  logic               sck_rise;
  logic [FRAME_W-1:0] shift_q;

  assign sck_rise = sck_i & ~sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      ld_prev_q  <= 1'b0;
      shift_q    <= '0;
    end else begin
      sck_prev_q <= sck_i;
      ld_prev_q  <= ld_i;
      if (clr_i)         shift_q <= '0;
      else if (sck_rise) shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
    end
  end

  assign frame_o  = frame_t'(shift_q);
  assign commit_o = ld_i & ~ld_prev_q & ~clr_i;

  // R1
  sdi_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise && !clr_i |=> shift_q[0] == $past(sdi_i));

  // R3
  shift_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise && !clr_i |=> shift_q[FRAME_W-1:1] == $past(shift_q[FRAME_W-2:0]));
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import cfg_loader_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          wr_i,
  input  frame_t                        frame_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= '0;
      else if (clr_i) regs_q[i] <= '0;
      else if (wr_i && frame_i.addr == ADDR_W'(i)) regs_q[i] <= frame_i.data;
    end
  end

  assign regs_o = regs_q;

  // R2
  hold_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i && !clr_i |=> $stable(regs_q));

  // R4
  reserved_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i && frame_i.addr >= ADDR_W'(NUM_REGS) |=> $stable(regs_q));

  // R5
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> regs_q == '0);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stby_ni,
  input  logic                  uv_i,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  input  logic                  ld_i,
  output logic [NPAIR-1:0]      pair_mode_o,
  output logic [NPAIR-1:0]      pair_step_o,
  output logic [NPAIR-1:0][1:0] pair_ccen_o,
  output logic [NPAIR-1:0][4:0] pair_div_o,
  output logic [NPAIR-1:0]      pair_coarse_o,
  output logic [NPAIR-1:0]      pair_cnt_rst_o,
  output logic [NPAIR-1:0][1:0] pair_fast_o,
  output logic [NPAIR-1:0]      pair_mon90_o,
  output logic [NPAIR-1:0][1:0] pair_ilim_o,
  output logic [NPAIR-1:0][1:0] pair_off_o,
  output logic [NPAIR-1:0]      pair_rev_o,
  output logic [NPAIR-1:0][3:0] pair_bridge_o,
  output logic                  e_mode_o,
  output logic                  e_ccen_o,
  output logic [4:0]            e_div_o,
  output logic [1:0]            e_off_o,
  output logic [1:0]            e_bridge_o,
  output logic [5:0]            e_dac_o,
  output logic [NAUX-1:0]       aux_mode_o,
  output logic [NAUX-1:0][1:0]  aux_bridge_o
);
  logic [2:0] pins_s;
  logic       clr, commit;
  frame_t     frame;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign clr = ~stby_ni | uv_i;

  sync_vec #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ld_i, sdi_i, sck_i}),
    .q_o   (pins_s)
  );

  frame_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .sck_i   (pins_s[0]),
    .sdi_i   (pins_s[1]),
    .ld_i    (pins_s[2]),
    .frame_o (frame),
    .commit_o(commit)
  );

  reg_bank u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .wr_i   (commit),
    .frame_i(frame),
    .regs_o (regs)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int B = p * REGS_PER_PAIR;
    assign pair_mode_o[p]    = regs[B][7];
    assign pair_step_o[p]    = regs[B][6];
    assign pair_div_o[p]     = regs[B][4:0];
    assign pair_ccen_o[p]    = {regs[B+1][2], regs[B][5]};
    assign pair_coarse_o[p]  = regs[B+1][7];
    assign pair_cnt_rst_o[p] = regs[B+1][6];
    assign pair_fast_o[p]    = regs[B+1][5:4];
    assign pair_mon90_o[p]   = regs[B+1][3];
    assign pair_ilim_o[p]    = regs[B+1][1:0];
    assign pair_off_o[p]     = regs[B+2][7:6];
    assign pair_rev_o[p]     = regs[B+2][5];
    assign pair_bridge_o[p]  = {regs[B+3][7:6], regs[B+2][4:3]};
  end

  assign e_mode_o   = regs[E_BASE][7];
  assign e_ccen_o   = regs[E_BASE][6];
  assign e_div_o    = regs[E_BASE][4:0];
  assign e_off_o    = regs[E_BASE+1][7:6];
  assign e_bridge_o = regs[E_BASE+1][5:4];
  assign e_dac_o    = regs[E_BASE+2][5:0];

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    assign aux_mode_o[k]   = regs[AUX_BASE+k][7];
    assign aux_bridge_o[k] = regs[AUX_BASE+k][6:5];
  end

  logic unused_bits;
  assign unused_bits = ^{regs[2][2:0], regs[3][5:0], regs[6][2:0], regs[7][5:0],
                         regs[E_BASE][5], regs[E_BASE+1][3:0], regs[E_BASE+2][7:6],
                         regs[AUX_BASE][4:0], regs[AUX_BASE+1][4:0], regs[AUX_BASE+2][4:0]};

  // R6
  uv_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (e_dac_o == '0 && pair_div_o == '0 && aux_mode_o == '0));
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stby_ni = 1'b1, uv_i = 1'b0, sck_i = 1'b0, sdi_i = 1'b0, ld_i = 1'b0;

  logic [1:0]      pair_mode_o, pair_step_o, pair_coarse_o, pair_cnt_rst_o, pair_mon90_o, pair_rev_o;
  logic [1:0][1:0] pair_ccen_o, pair_fast_o, pair_ilim_o, pair_off_o;
  logic [1:0][4:0] pair_div_o;
  logic [1:0][3:0] pair_bridge_o;
  logic            e_mode_o, e_ccen_o;
  logic [4:0]      e_div_o;
  logic [1:0]      e_off_o, e_bridge_o;
  logic [5:0]      e_dac_o;
  logic [2:0]      aux_mode_o;
  logic [2:0][1:0] aux_bridge_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_loader u_cfg_serial_loader (
    .clk_i(clk), .rst_ni(rst_ni), .stby_ni(stby_ni), .uv_i(uv_i),
    .sck_i(sck_i), .sdi_i(sdi_i), .ld_i(ld_i),
    .pair_mode_o(pair_mode_o), .pair_step_o(pair_step_o), .pair_ccen_o(pair_ccen_o),
    .pair_div_o(pair_div_o), .pair_coarse_o(pair_coarse_o), .pair_cnt_rst_o(pair_cnt_rst_o),
    .pair_fast_o(pair_fast_o), .pair_mon90_o(pair_mon90_o), .pair_ilim_o(pair_ilim_o),
    .pair_off_o(pair_off_o), .pair_rev_o(pair_rev_o), .pair_bridge_o(pair_bridge_o),
    .e_mode_o(e_mode_o), .e_ccen_o(e_ccen_o), .e_div_o(e_div_o), .e_off_o(e_off_o),
    .e_bridge_o(e_bridge_o), .e_dac_o(e_dac_o), .aux_mode_o(aux_mode_o),
    .aux_bridge_o(aux_bridge_o)
  );

  wire [71:0] all_o = {pair_mode_o, pair_step_o, pair_ccen_o, pair_div_o, pair_coarse_o,
                       pair_cnt_rst_o, pair_fast_o, pair_mon90_o, pair_ilim_o, pair_off_o,
                       pair_rev_o, pair_bridge_o, e_mode_o, e_ccen_o, e_div_o, e_off_o,
                       e_bridge_o, e_dac_o, aux_mode_o, aux_bridge_o};

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdi_i = bits[i];
      repeat (SCK_HALF) @(negedge clk); sck_i = 1'b1;
      repeat (SCK_HALF) @(negedge clk); sck_i = 1'b0;
    end
    repeat (SCK_HALF) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); ld_i = 1'b1;
    repeat (6) @(negedge clk); ld_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
    shift_bits({4'h0, a, d}, 12);
    strobe();
  endtask

  task automatic t_reset();
    chk("R11 reset outputs", all_o, '0);
  endtask

  task automatic t_pair_base();
    logic [71:0] snap;
    write_reg(4'd0, 8'b1_1_1_10101);
    chk("R1 R7 pair0 mode", 72'(pair_mode_o), 72'(2'b01));
    chk("R7 pair0 step", 72'(pair_step_o), 72'(2'b01));
    chk("R7 pair0 div", 72'(pair_div_o[0]), 72'(21));
    chk("R10 pair1 div untouched", 72'(pair_div_o[1]), 72'(0));
    snap = all_o;
    shift_bits({4'h0, 4'd1, 8'b1_1_10_1_1_11}, 12);
    chk("R2 no change before strobe", all_o, snap);
    strobe();
    chk("R7 pair0 ccen", 72'(pair_ccen_o[0]), 72'(2'b11));
    chk("R7 pair0 coarse/cntrst/mon", 72'({pair_coarse_o[0], pair_cnt_rst_o[0], pair_mon90_o[0]}), 72'(3'b111));
    chk("R7 pair0 fast", 72'(pair_fast_o[0]), 72'(2));
    chk("R7 pair0 ilim", 72'(pair_ilim_o[0]), 72'(3));
    chk("R10 pair0 div kept", 72'(pair_div_o[0]), 72'(21));
  endtask

  task automatic t_pair1_bridge();
    write_reg(4'd6, 8'b10_1_10_000);
    chk("R7 pair1 off", 72'(pair_off_o[1]), 72'(2));
    chk("R7 pair1 rev", 72'(pair_rev_o), 72'(2'b10));
    chk("R7 pair1 bridge a", 72'(pair_bridge_o[1]), 72'(4'b0010));
    write_reg(4'd7, 8'b01_000000);
    chk("R7 pair1 bridge b", 72'(pair_bridge_o[1]), 72'(4'b0110));
    chk("R10 pair0 bridge untouched", 72'(pair_bridge_o[0]), 72'(0));
  endtask

  task automatic t_chan_e();
    write_reg(4'd8, 8'b1_1_0_00111);
    write_reg(4'd9, 8'b11_0_1_0000);
    write_reg(4'd10, 8'b00_101101);
    chk("R8 e mode/ccen", 72'({e_mode_o, e_ccen_o}), 72'(2'b11));
    chk("R8 e div", 72'(e_div_o), 72'(7));
    chk("R8 e off", 72'(e_off_o), 72'(3));
    chk("R8 e bridge", 72'(e_bridge_o), 72'(2'b01));
    chk("R8 e dac", 72'(e_dac_o), 72'(45));
  endtask

  task automatic t_aux();
    write_reg(4'd12, 8'b1_1_0_00000);
    chk("R9 aux mode", 72'(aux_mode_o), 72'(3'b010));
    chk("R9 aux bridge", 72'(aux_bridge_o[1]), 72'(2'b10));
  endtask

  task automatic t_reserved();
    logic [71:0] snap;
    snap = all_o;
    write_reg(4'd14, 8'hFF);
    chk("R4 addr14 ignored", all_o, snap);
    write_reg(4'd15, 8'h00);
    chk("R4 addr15 ignored", all_o, snap);
  endtask

  task automatic t_overlength();
    shift_bits({1'b0, 3'b111, 4'd11, 8'b1_0_1_00000}, 15);
    strobe();
    chk("R3 long frame aux0 mode", 72'(aux_mode_o[0]), 72'(1));
    chk("R3 long frame aux0 bridge", 72'(aux_bridge_o[0]), 72'(2'b01));
  endtask

  task automatic t_timing();
    shift_bits({4'h0, 4'd10, 8'b00_010011}, 12);
    @(negedge clk); ld_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 old value after 2 edges", 72'(e_dac_o), 72'(45));
    @(negedge clk);
    chk("R12 new value after 3 edges", 72'(e_dac_o), 72'(19));
    repeat (4) @(negedge clk); ld_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_standby();
    @(negedge clk); stby_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 standby clears", all_o, '0);
    write_reg(4'd0, 8'hFF);
    chk("R5 write lost in standby", all_o, '0);
    @(negedge clk); stby_ni = 1'b1;
    write_reg(4'd13, 8'b1_1_1_00000);
    chk("R5 loads after standby", 72'(aux_mode_o), 72'(3'b100));
  endtask

  task automatic t_uv();
    write_reg(4'd4, 8'b0_0_0_11111);
    chk("R7 pair1 div", 72'(pair_div_o[1]), 72'(31));
    @(negedge clk); uv_i = 1'b1;
    @(negedge clk); uv_i = 1'b0;
    @(negedge clk);
    chk("R6 undervoltage clears", all_o, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pair_base();
    t_pair1_bridge();
    t_chan_e();
    t_aux();
    t_reserved();
    t_overlength();
    t_timing();
    t_standby();
    t_uv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule